// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked system reach an external asynchronous static RAM of 256K sixteen-bit words. The RAM is selected by two enables of opposite polarity and has a separate active-low select for each byte lane. The user side presents a one-cycle request that carries a word address, a read/write flag, two byte-enable bits and write data. The block then performs one complete memory access. It signals the end of the access with a one-cycle done pulse, and for a read it returns the captured word.

None of the RAM's timing limits is expressed in nanoseconds inside the logic. Each limit is converted into a whole number of clock cycles from the clock-period parameter, by rounding up, with at least one cycle per phase. Every memory-side control is a register output. The data bus is split into an output word, a single output-enable and an input word. The block drives that bus only when the RAM cannot be driving it: the output enable must have been high for the release time, and the write strobe must not yet have risen.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the controller is idle: `busy` and `done` are 0, `mem_dq_oe` is 0, and `mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_lsel_n` and `mem_usel_n` are 1 while `mem_cs` is 0.
- R2: Whenever `busy` is low, the RAM is deselected (`mem_cs_n`=1, `mem_cs`=0) and both strobes are high.
- R3: A read holds `mem_oe_n` low, `mem_we_n` high and the chip selected for RD = ceil(max(55,30)/T) cycles (14 at T=4 ns). It then captures `mem_dq_i` into `rd_data` with every lane zeroed whose enable bit is 0. `req_be[0]` drives the lower lane (bits 7:0, `mem_lsel_n` = !be[0]) and `req_be[1]` drives the upper lane (bits 15:8, `mem_usel_n` = !be[1]).
- R4: A write asserts the chip and the lane selects for one setup cycle with `mem_we_n` high. It then holds `mem_we_n` low for WP = max(ceil(35/T), ceil(45/T)-1, ceil(25/T)-1) cycles (11 at T=4 ns). Only the lanes whose enable bit is 1 change in the RAM; with `req_be`=0 no byte changes.
- R5: From the clock edge that accepts a request to the edge that raises `done` there are RD edges for a read, and 1+WP+WR edges for a write, where WR = max(1, ceil(55/T)-1-WP). Both are 14 at T=4 ns.
- R6: `mem_addr` changes only on an edge where `mem_we_n` is high both before and after that edge.
- R7: `mem_dq_oe` is high only while `mem_oe_n` is high, and only in the write setup and strobe cycles. It falls on the edge where `mem_we_n` rises.
- R8: After a read, `mem_dq_oe` stays low until `mem_oe_n` has been high for at least TA = ceil(25/T) cycles (7 at T=4 ns).
- R9: A request is accepted only while `busy` is low. A request raised while `busy` is high starts no access and changes no memory word.
- R10: `done` is a single-cycle pulse, given once for each accepted request. `rd_data` is valid while `done` is high after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lsel_n | output | 1 | Active-low lower-lane select |
| mem_usel_n | output | 1 | Active-low upper-lane select |
| mem_dq_o | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Output enable for the data bus |
| mem_dq_i | input | 16 | Data received from the bus |

## Verification
The assertions assume that `req` is a single-cycle strobe and that the attached RAM drives the bus only while it is selected for reading. They also assume it stops driving within the release time after `mem_oe_n` rises. The bench's RAM model obeys exactly that: it keeps driving for six cycles after the read ends, one cycle fewer than TA, so any early bus drive shows up as a clash. The same model places a filler byte on deselected lanes to expose any missing masking. The stimulus raises `req` only at falling edges. Its one deliberate violation is a request held during `busy`, which the design must ignore.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int T_ACC_NS      = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WP_NS       = 35,
  parameter int T_AW_NS       = 45,
  parameter int T_DS_NS       = 25,
  parameter int T_WC_NS       = 55,
  parameter int T_REL_NS      = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lsel_n,
  output logic              mem_usel_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LANE_W = DATA_W / 2;
  localparam int RD_CYC = ns2cyc(imax(T_ACC_NS, T_OE_NS));
  localparam int WP_CYC = imax(ns2cyc(T_WP_NS), imax(ns2cyc(T_AW_NS) - 1, ns2cyc(T_DS_NS) - 1));
  localparam int WR_CYC = imax(1, ns2cyc(T_WC_NS) - 1 - WP_CYC);
  localparam int TA_CYC = ns2cyc(T_REL_NS);
  localparam int MAX_C  = imax(imax(RD_CYC, WP_CYC), imax(WR_CYC, TA_CYC));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    IDLE, READ_ACCESS, READ_CAPTURE, WRITE_SETUP, WRITE_PULSE, WRITE_RECOVER, TURNAROUND
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  always_comb begin
    case (st)
      READ_ACCESS:   cnt_last = (cnt == CNT_W'(RD_CYC - 1));
      WRITE_PULSE:   cnt_last = (cnt == CNT_W'(WP_CYC - 1));
      WRITE_RECOVER: cnt_last = (cnt == CNT_W'(WR_CYC - 1));
      TURNAROUND:    cnt_last = (cnt == CNT_W'(TA_CYC - 1));
      default:       cnt_last = 1'b1;
    endcase
  end

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      done       <= 1'b0;
      rd_data    <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_cs     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lsel_n <= 1'b1;
      mem_usel_n <= 1'b1;
      mem_dq_o   <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt_last ? '0 : cnt + 1'b1;
      case (st)
        IDLE: begin
          cnt <= '0;
          if (req) begin
            mem_addr   <= req_addr;
            mem_lsel_n <= !req_be[0];
            mem_usel_n <= !req_be[1];
            mem_cs_n   <= 1'b0;
            mem_cs     <= 1'b1;
            if (req_we) begin
              mem_dq_o  <= req_wdata;
              mem_dq_oe <= 1'b1;
              st        <= WRITE_SETUP;
            end else begin
              mem_oe_n <= 1'b0;
              st       <= READ_ACCESS;
            end
          end
        end
        READ_ACCESS: if (cnt_last) begin
          rd_data    <= mem_dq_i & {{LANE_W{!mem_usel_n}}, {LANE_W{!mem_lsel_n}}};
          done       <= 1'b1;
          mem_oe_n   <= 1'b1;
          mem_cs_n   <= 1'b1;
          mem_cs     <= 1'b0;
          mem_lsel_n <= 1'b1;
          mem_usel_n <= 1'b1;
          st         <= READ_CAPTURE;
        end
        READ_CAPTURE: st <= TURNAROUND;
        TURNAROUND: if (cnt_last) st <= IDLE;
        WRITE_SETUP: begin
          mem_we_n <= 1'b0;
          st       <= WRITE_PULSE;
        end
        WRITE_PULSE: if (cnt_last) begin
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          st        <= WRITE_RECOVER;
        end
        WRITE_RECOVER: if (cnt_last) begin
          done       <= 1'b1;
          mem_cs_n   <= 1'b1;
          mem_cs     <= 1'b0;
          mem_lsel_n <= 1'b1;
          mem_usel_n <= 1'b1;
          st         <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] oe_hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                            oe_hi_cnt <= CNT_W'(TA_CYC);
    else if (!mem_oe_n)                    oe_hi_cnt <= '0;
    else if (oe_hi_cnt < CNT_W'(TA_CYC))   oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n));

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs && !mem_dq_oe));

  assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n && mem_dq_oe));

  assert_addr_we_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && oe_hi_cnt >= CNT_W'(TA_CYC)));

  assert_busy_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  localparam int T = 4;

  function automatic int cdiv(input int ns);
    return (ns + T - 1) / T;
  endfunction

  localparam int RD_EXP  = cdiv(55);
  localparam int WP_EXP  = (cdiv(35) > cdiv(45) - 1) ? cdiv(35) : cdiv(45) - 1;
  localparam int WR_EXP  = (cdiv(55) - 1 - WP_EXP < 1) ? 1 : cdiv(55) - 1 - WP_EXP;
  localparam int TA_EXP  = cdiv(25);
  localparam int RLAT    = RD_EXP + 1;
  localparam int WLAT    = 1 + WP_EXP + WR_EXP + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done;
  logic [15:0] rd_data, mem_dq_o;
  logic [17:0] mem_addr;
  logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lsel_n, mem_usel_n, mem_dq_oe;
  logic [15:0] mem_dq_i = 16'h5A5A;

  always #2 clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lsel_n(mem_lsel_n), .mem_usel_n(mem_usel_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int checks = 0, errors = 0;
  int m_checks = 0, m_errors = 0;

  logic [15:0] ram    [int];
  logic [15:0] shadow [int];

  int hold = 0, we_run = 0, oe_run = 0, oe_hi = 100;
  logic prev_dq_oe = 1'b0;

  always @(negedge clk) if (rst_n) begin
    logic sel, rd_drv;
    logic [15:0] w;
    sel    = !mem_cs_n && mem_cs && !(mem_lsel_n && mem_usel_n);
    rd_drv = sel && mem_we_n && !mem_oe_n;
    m_checks++;
    if (mem_dq_oe && (rd_drv || hold > 0)) begin
      m_errors++; $display("FAIL R7/R8: bus clash, dq_oe=%b ram_drive=1 expected ram_drive=0", mem_dq_oe);
    end
    if (!busy) begin
      m_checks++;
      if (!(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n)) begin
        m_errors++; $display("FAIL R2: idle selects cs_n=%b cs=%b we_n=%b oe_n=%b expected 1 0 1 1",
                             mem_cs_n, mem_cs, mem_we_n, mem_oe_n);
      end
    end
    if (mem_dq_oe && !prev_dq_oe) begin
      m_checks++;
      if (oe_hi < TA_EXP) begin
        m_errors++; $display("FAIL R8: oe high %0d cycles before drive, expected >= %0d", oe_hi, TA_EXP);
      end
    end
    prev_dq_oe = mem_dq_oe;
    if (!mem_oe_n) oe_hi = 0; else oe_hi++;
    if (rd_drv) hold = TA_EXP - 1; else if (hold > 0) hold--;
    if (!mem_we_n) we_run++;
    else if (we_run > 0) begin
      m_checks++;
      if (we_run != WP_EXP) begin
        m_errors++; $display("FAIL R4: write strobe %0d cycles expected %0d", we_run, WP_EXP);
      end
      we_run = 0;
    end
    if (!mem_oe_n) oe_run++;
    else if (oe_run > 0) begin
      m_checks++;
      if (oe_run != RD_EXP) begin
        m_errors++; $display("FAIL R3: read strobe %0d cycles expected %0d", oe_run, RD_EXP);
      end
      oe_run = 0;
    end
    if (sel && !mem_we_n) begin
      w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
      if (!mem_lsel_n) w[7:0]  = mem_dq_o[7:0];
      if (!mem_usel_n) w[15:8] = mem_dq_o[15:8];
      ram[int'(mem_addr)] = w;
    end
    w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
    if (mem_dq_oe)                mem_dq_i = mem_dq_o;
    else if (rd_drv || hold > 0)  mem_dq_i = {mem_usel_n ? 8'hA5 : w[15:8], mem_lsel_n ? 8'hA5 : w[7:0]};
    else                          mem_dq_i = 16'h5A5A;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic we, input logic [17:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    while (busy) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      req = 1'b0;
      lat++;
    end while (!done && lat < 100);
    rd = rd_data;
  endtask

  function automatic logic [15:0] lanes(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic write_chk(input logic [17:0] a, input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] rd, old;
    int lat;
    run_op(1'b1, a, be, wd, rd, lat);
    chk("R5 write latency", lat, WLAT);
    chk("R10 done once", {31'd0, done}, 32'd1);
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    shadow[int'(a)] = (old & ~lanes(be)) | (wd & lanes(be));
  endtask

  task automatic read_chk(input logic [17:0] a, input logic [1:0] be);
    logic [15:0] rd, exp;
    int lat;
    run_op(1'b0, a, be, 16'h0, rd, lat);
    chk("R5 read latency", lat, RLAT);
    exp = (shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0) & lanes(be);
    chk("R3 R4 read data by lane", rd, exp);
    @(negedge clk);
    chk("R10 single pulse", {31'd0, done}, 32'd0);
  endtask

  logic [17:0] addrs [5] = '{18'h00000, 18'h00001, 18'h155AA, 18'h3FFFF, 18'h20000};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy/done/oe", {busy, done, mem_dq_oe}, 3'b000);
    chk("R1 reset strobes", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lsel_n, mem_usel_n}, 6'b101111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle idle", {busy, done, mem_dq_oe, mem_cs_n, mem_cs, mem_we_n, mem_oe_n}, 7'b0001011);

    foreach (addrs[i]) begin
      write_chk(addrs[i], 2'b11, addrs[i][15:0] ^ 16'hC3C3);
      for (int bw = 0; bw < 4; bw++) begin
        write_chk(addrs[i], 2'(bw), addrs[i][15:0] ^ (16'(bw) * 16'h1111) ^ 16'h0F0F);
        for (int br = 0; br < 4; br++) read_chk(addrs[i], 2'(br));
      end
    end

    begin : ignore_busy_R9
      logic [15:0] rd;
      int lat, extra;
      write_chk(18'h00100, 2'b11, 16'h1234);
      write_chk(18'h00200, 2'b11, 16'hABCD);
      while (busy) @(negedge clk);
      req = 1'b1; req_we = 1'b1; req_addr = 18'h00100; req_be = 2'b11; req_wdata = 16'h7777;
      @(negedge clk);
      req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 busy during op", {31'd0, busy}, 32'd1);
      req = 1'b1; req_addr = 18'h00200; req_wdata = 16'hDEAD;
      @(negedge clk);
      req = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      shadow[32'h100] = 16'h7777;
      extra = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (busy) extra++; end
      chk("R9 no access started while busy", extra, 0);
      read_chk(18'h00200, 2'b11);
      read_chk(18'h00100, 2'b11);
      run_op(1'b1, 18'h00200, 2'b00, 16'h0000, rd, lat);
      chk("R4 empty enable write latency", lat, WLAT);
      read_chk(18'h00200, 2'b11);
    end

    report(0);
  end

  task automatic report(input int wd);
    $display("Simulation finished: %0d checks, %0d errors", checks + m_checks + wd, errors + m_errors + wd);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report(1);
  end
endmodule